// File: doc/BRIEF.md
# SPI Pad Timing Adjuster

This block sits between a SPI master's bit shifter and the I/O pads. It moves the outgoing serial data later by zero to three core clock cycles. It moves the incoming serial data later by zero to three cycles. It also shifts the receive sampling point anywhere from two cycles before the nominal sampling edge to one cycle after it. These settings let the shifter keep fixed internal timing while the board delays of the pads and of the slave are absorbed at the edge.

The shifter supplies an advance strobe. This is a one-cycle pulse issued two core cycles before each nominal sampling edge. Sampling earlier than nominal is therefore a matter of using that strobe directly or one cycle later. Sampling at or after the nominal edge delays the strobe further. The three settings are static 2-bit inputs. The block captures them only while the shifter reports that it is idle. A setting that changes while a word is being shifted takes effect only after the shifter becomes idle again.

Top module: `spi_io_skew`

## Requirements
- R1: While reset is asserted and right after it, `rx_valid_o` and `rx_bit_o` are 0 and all three held settings are 0, so `mosi_o` follows `mosi_i` in the same cycle.
- R2: With a held output delay of m (0..3), `mosi_o` in cycle n equals `mosi_i` from cycle n-m.
- R3: With a held input delay of d (0..3), the bit that is sampled at a given cycle is `miso_i` from d cycles earlier.
- R4: Suppose `cap_early_i` is high in cycle k, and the nominal edge is therefore cycle k+2. The held capture code c then samples in cycle k+c. Code 0 is two cycles early, code 1 is one cycle early, code 2 is nominal and code 3 is one cycle late.
- R5: `rx_valid_o` is high for exactly the one cycle after each sampling cycle, and `rx_bit_o` presents the sampled bit from that cycle until the next capture.
- R6: A clock edge with `busy_i` low loads all three settings. A clock edge with `busy_i` high leaves the held settings unchanged, so setting changes during a word have no effect.
- R7: Advance strobes in consecutive cycles each yield their own capture, in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy_i | input | 1 | Shifter is in a word; settings are frozen while high |
| mo_dly_i | input | 2 | Output data delay in cycles (0..3) |
| mi_dly_i | input | 2 | Input data delay in cycles (0..3) |
| cap_sel_i | input | 2 | Capture point code: 0 = -2, 1 = -1, 2 = nominal, 3 = +1 |
| mosi_i | input | 1 | Serial output data from the shifter |
| miso_i | input | 1 | Raw serial input data from the pad |
| cap_early_i | input | 1 | Advance strobe, two cycles before the nominal sampling edge |
| mosi_o | output | 1 | Delayed serial output data to the pad |
| rx_bit_o | output | 1 | Last captured receive bit |
| rx_valid_o | output | 1 | One-cycle pulse marking a new captured bit |

## Verification
The hardest case to reach from the ports combines capture code and input delay. Together they pick which single past cycle of `miso_i` ends up on `rx_bit_o`, and a constant or slowly changing input hides an error of a cycle or two. The stimulus therefore drives `miso_i` and `mosi_i` from irregular bit patterns indexed by cycle. For each setting combination it predicts both the cycle of `rx_valid_o` and the exact pattern index that must be captured. It also moves the setting inputs to different values in the middle of every word, so that any leak of the frozen settings shows up as a wrong index.

// File: rtl/spi_io_skew.sv
module spi_io_skew #(
  parameter int MAX_DLY = 3,
  localparam int SW = $clog2(MAX_DLY + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy_i,
  input  logic [SW-1:0] mo_dly_i,
  input  logic [SW-1:0] mi_dly_i,
  input  logic [SW-1:0] cap_sel_i,
  input  logic          mosi_i,
  input  logic          miso_i,
  input  logic          cap_early_i,
  output logic          mosi_o,
  output logic          rx_bit_o,
  output logic          rx_valid_o
);

  logic [SW-1:0]      mo_q, mi_q, cap_q;
  logic [MAX_DLY-1:0] mo_sr, mi_sr, st_sr;
  logic [MAX_DLY:0]   mo_line, mi_line, st_line;
  logic               miso_d, strobe;

  assign mo_line = {mo_sr, mosi_i};
  assign mi_line = {mi_sr, miso_i};
  assign st_line = {st_sr, cap_early_i};

  assign mosi_o = mo_line[mo_q];
  assign miso_d = mi_line[mi_q];
  assign strobe = st_line[cap_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mo_q  <= '0;
      mi_q  <= '0;
      cap_q <= '0;
    end else if (!busy_i) begin
      mo_q  <= mo_dly_i;
      mi_q  <= mi_dly_i;
      cap_q <= cap_sel_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mo_sr <= '0;
      mi_sr <= '0;
      st_sr <= '0;
    end else begin
      mo_sr <= mo_line[MAX_DLY-1:0];
      mi_sr <= mi_line[MAX_DLY-1:0];
      st_sr <= st_line[MAX_DLY-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_bit_o   <= 1'b0;
      rx_valid_o <= 1'b0;
    end else begin
      rx_valid_o <= strobe;
      if (strobe) rx_bit_o <= miso_d;
    end
  end

  // R6
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> ($stable(mo_q) && $stable(mi_q) && $stable(cap_q)));

  // R6
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_i |=> (mo_q == $past(mo_dly_i) && mi_q == $past(mi_dly_i) && cap_q == $past(cap_sel_i)));

  // R2
  mosi_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mo_q == '0) |-> (mosi_o == mosi_i));

  // R2
  mosi_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mo_q == SW'(1)) |-> (mosi_o == $past(mosi_i)));

  // R4
  cap_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && cap_q == '0 && mi_q == '0 && cap_early_i) |=> (rx_valid_o && rx_bit_o == $past(miso_i)));

  // R5
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && cap_q == '0 && !cap_early_i) |=> !rx_valid_o);

endmodule

// File: tb/spi_io_skew_tb.sv
module spi_io_skew_tb_top;
  localparam int PER = 10;
  localparam logic [23:0] PA = 24'hB4D2E6;
  localparam logic [23:0] PB = 24'h5A3C96;
  localparam logic [5:0] VEC [8] = '{6'b00_00_00, 6'b01_01_01, 6'b10_10_10, 6'b11_11_11,
                                     6'b00_11_00, 6'b11_00_11, 6'b01_10_11, 6'b10_01_00};

  logic clk = 1'b0, rst_n = 1'b0, busy_i = 1'b0;
  logic [1:0] mo_dly_i = 2'd3, mi_dly_i = 2'd3, cap_sel_i = 2'd3;
  logic mosi_i = 1'b0, miso_i = 1'b0, cap_early_i = 1'b0;
  logic mosi_o, rx_bit_o, rx_valid_o;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #(PER/2) clk = ~clk;

  spi_io_skew dut_i (.clk(clk), .rst_n(rst_n), .busy_i(busy_i), .mo_dly_i(mo_dly_i),
    .mi_dly_i(mi_dly_i), .cap_sel_i(cap_sel_i), .mosi_i(mosi_i), .miso_i(miso_i),
    .cap_early_i(cap_early_i), .mosi_o(mosi_o), .rx_bit_o(rx_bit_o), .rx_valid_o(rx_valid_o));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_case(input logic [1:0] m, input logic [1:0] d, input logic [1:0] c, input bit dbl);
    int e1, e2;
    e1 = 9 + int'(c);
    e2 = 10 + int'(c);
    for (int n = 0; n < 24; n++) begin
      @(negedge clk);
      busy_i      = (n >= 2);
      mo_dly_i    = (n >= 3) ? ~m : m;
      mi_dly_i    = (n >= 3) ? ~d : d;
      cap_sel_i   = (n >= 3) ? ~c : c;
      mosi_i      = PB[n];
      miso_i      = PA[n];
      cap_early_i = (n == 8) || (dbl && n == 9);
      #(PER/4);
      if (n >= 5) chk("R2/R6 mosi delay", mosi_o, PB[n - int'(m)]);
      if (n >= 5) begin
        if ((n == e1) || (dbl && n == e2)) begin
          chk(dbl ? "R7 back-to-back valid" : "R4/R5 valid timing", rx_valid_o, 1'b1);
          chk(dbl ? "R7 back-to-back bit" : "R3/R4 captured bit", rx_bit_o, PA[n - 1 - int'(d)]);
        end else begin
          chk("R5/R6 no extra valid", rx_valid_o, 1'b0);
        end
      end
    end
  endtask

  initial begin
    #(PER * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    mosi_i = 1'b1;
    #(PER*2 + PER/4);
    // R1 reset state
    chk("R1 valid in reset", rx_valid_o, 1'b0);
    chk("R1 bit in reset", rx_bit_o, 1'b0);
    chk("R1 mosi passthrough high", mosi_o, 1'b1);
    mosi_i = 1'b0;
    #1;
    chk("R1 mosi passthrough low", mosi_o, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    busy_i = 1'b1;
    mosi_i = 1'b1;
    #(PER/4);
    chk("R1 mosi after reset", mosi_o, 1'b1);
    chk("R1 valid after reset", rx_valid_o, 1'b0);
    foreach (VEC[i]) run_case(VEC[i][5:4], VEC[i][3:2], VEC[i][1:0], 1'b0);
    // R7 consecutive strobes
    run_case(2'd0, 2'd0, 2'd3, 1'b1);
    run_case(2'd2, 2'd1, 2'd0, 1'b1);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule